// File: doc/BRIEF.md
# Branch Sequencer with Hidden Return Stack

This block owns the 16-bit program counter of an 8-bit stack machine whose program memory is separate from its data memory and up to 64 KB in size. Each cycle it may receive one decoded control operation. The operation arrives with a 16-bit target, the encoded instruction length, the two top bytes of the data stack and the carry flag. From these the block picks the next fetch address. In the same cycle it tells the data-stack logic whether to drop an entry.

Calls and returns use a private last-in-first-out store of return addresses. Program code cannot read or write this store. A return with nothing saved, or a call with no room left, sets a sticky error flag. The machine then keeps running in a defined way.

The request side is a plain valid strobe with no ready. The sequencer accepts one operation every cycle and never applies back-pressure. `pop_req`, `pop_cnt` and `taken` are combinational from the presented operation. `pc` and the error flags change at the next rising edge.

Top module: `branch_seq`

## Requirements
- R1: After reset (`rst_n` low), `pc` is 0x0000, both error flags are 0 and the return store is empty, so a return issued right after reset underflows.
- R2: While `op_valid` is 0, `pc` holds and `pop_req` and `taken` are 0.
- R3: The non-control codes are 0 and 10 to 15. A valid operation with one of these codes, or a valid branch that is not taken, advances `pc` by `op_len` (1 or 3). The addition wraps modulo 65536.
- R4: Code 1 (jump) always loads `op_target` into `pc` at the next edge, asserts `taken` and requests no pop.
- R5: Code 2 (jump-if-zero) and code 3 (jump-if-nonzero) always assert `pop_req` with `pop_cnt` = 1. The branch is taken when `tos` is zero (code 2) or nonzero (code 3).
- R6: Code 4 (jump-if-carry) and code 5 (jump-if-no-carry) never request a pop. The branch is taken when `carry` is 1 (code 4) or 0 (code 5).
- R7: Code 6 (jump-if-equal) and code 7 (jump-if-not-equal) request exactly one pop (`pop_cnt` = 1), so `nos` stays on the stack. The branch is taken when `tos` equals `nos` (code 6) or differs from it (code 7).
- R8: Code 8 (call) loads `op_target` into `pc`, asserts `taken` and saves `pc` + 3 on the return store.
- R9: Code 9 (return) with a non-empty store loads the most recently saved address into `pc` and removes it. Nesting works to a depth of 16.
- R10: A return with an empty store sets the sticky `rs_underflow`, leaves `taken` at 0 and advances `pc` by `op_len`.
- R11: A call while 16 addresses are held sets the sticky `rs_overflow` and still jumps. The address is not saved and the 16 held entries stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Decoded control-operation code |
| op_target | input | 16 | Branch or call target |
| op_len | input | 2 | Instruction length in bytes (1 or 3) |
| tos | input | 8 | Top data-stack byte |
| nos | input | 8 | Second data-stack byte |
| carry | input | 1 | Carry flag |
| pc | output | 16 | Program counter |
| pop_req | output | 1 | Drop entries from the data stack this cycle |
| pop_cnt | output | 2 | Number of entries to drop |
| taken | output | 1 | Control transfer happens this cycle |
| rs_underflow | output | 1 | Sticky: return issued on an empty store |
| rs_overflow | output | 1 | Sticky: call issued on a full store |

## Verification
Two of the block's functions can fall in the same cycle. A call made at full depth must jump and also raise the overflow flag, while leaving the saved addresses alone. A return on an empty store must raise the underflow flag while the counter still advances by the length. The bench nests sixteen calls and then issues a seventeenth. It then unwinds all sixteen, and each address must come back in reverse order. A final return must fall through with underflow. A behavioural queue model predicts every cycle, including a long stretch of randomly mixed operations, and compares each cycle against the design.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_JMP  = 4'd1,
    OP_JZ   = 4'd2,
    OP_JNZ  = 4'd3,
    OP_JC   = 4'd4,
    OP_JNC  = 4'd5,
    OP_JEQ  = 4'd6,
    OP_JNE  = 4'd7,
    OP_CALL = 4'd8,
    OP_RET  = 4'd9
  } ctl_op_e;
endpackage

// File: rtl/bseq_cond.sv
module bseq_cond
  import bseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] tos,
  input  logic [DW-1:0] nos,
  input  logic          carry,
  output logic          br_take,
  output logic          br_pop,
  output logic          is_call,
  output logic          is_ret
);
  ctl_op_e op;
  logic    tos_zero;
  logic    top_eq;

  assign op       = ctl_op_e'(op_code);
  assign tos_zero = (tos == '0);
  assign top_eq   = (tos == nos);

  always_comb begin
    br_take = 1'b0;
    br_pop  = 1'b0;
    is_call = 1'b0;
    is_ret  = 1'b0;
    case (op)
      OP_JMP:  br_take = 1'b1;
      OP_JZ:   begin br_pop = 1'b1; br_take = tos_zero;  end
      OP_JNZ:  begin br_pop = 1'b1; br_take = !tos_zero; end
      OP_JC:   br_take = carry;
      OP_JNC:  br_take = !carry;
      OP_JEQ:  begin br_pop = 1'b1; br_take = top_eq;    end
      OP_JNE:  begin br_pop = 1'b1; br_take = !top_eq;   end
      OP_CALL: is_call = 1'b1;
      OP_RET:  is_ret  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/bseq_rstack.sv
module bseq_rstack #(
  parameter int DEPTH = 16,
  parameter int AW_PC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [AW_PC-1:0] push_addr,
  output logic [AW_PC-1:0] top_addr,
  output logic             empty,
  output logic             full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = IW + 1;

  logic [AW_PC-1:0] slot [DEPTH];
  logic [CW-1:0]    fill_q;
  logic [IW-1:0]    wr_idx;
  logic [IW-1:0]    rd_idx;

  assign wr_idx   = IW'(fill_q);
  assign rd_idx   = IW'(fill_q - CW'(1));
  assign empty    = (fill_q == '0);
  assign full     = (fill_q == CW'(DEPTH));
  assign top_addr = slot[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (push && !full) begin
      fill_q <= fill_q + CW'(1);
    end else if (pop && !empty) begin
      fill_q <= fill_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) slot[wr_idx] <= push_addr;
  end
endmodule

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter int PCW      = 16,
  parameter int DW       = 8,
  parameter int RS_DEPTH = 16,
  parameter int CALL_LEN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [PCW-1:0] op_target,
  input  logic [1:0]     op_len,
  input  logic [DW-1:0]  tos,
  input  logic [DW-1:0]  nos,
  input  logic           carry,
  output logic [PCW-1:0] pc,
  output logic           pop_req,
  output logic [1:0]     pop_cnt,
  output logic           taken,
  output logic           rs_underflow,
  output logic           rs_overflow
);
  logic           br_take, br_pop, is_call, is_ret;
  logic           rs_empty, rs_full;
  logic [PCW-1:0] rs_top;
  logic [PCW-1:0] pc_q, pc_d, pc_seq, ret_addr;
  logic           call_go, ret_ok, ret_bad, push_en;
  logic           unf_q, ovf_q;

  bseq_cond #(.DW(DW)) u_cond (
    .op_code (op_code),
    .tos     (tos),
    .nos     (nos),
    .carry   (carry),
    .br_take (br_take),
    .br_pop  (br_pop),
    .is_call (is_call),
    .is_ret  (is_ret)
  );

  assign call_go  = op_valid && is_call;
  assign ret_ok   = op_valid && is_ret && !rs_empty;
  assign ret_bad  = op_valid && is_ret && rs_empty;
  assign push_en  = call_go && !rs_full;
  assign ret_addr = pc_q + PCW'(CALL_LEN);
  assign pc_seq   = pc_q + PCW'(op_len);

  bseq_rstack #(.DEPTH(RS_DEPTH), .AW_PC(PCW)) u_rs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_en),
    .pop       (ret_ok),
    .push_addr (ret_addr),
    .top_addr  (rs_top),
    .empty     (rs_empty),
    .full      (rs_full)
  );

  assign taken   = op_valid && (br_take || is_call || ret_ok);
  assign pop_req = op_valid && br_pop;
  assign pop_cnt = pop_req ? 2'd1 : 2'd0;

  always_comb begin
    if (!op_valid)   pc_d = pc_q;
    else if (ret_ok) pc_d = rs_top;
    else if (taken)  pc_d = op_target;
    else             pc_d = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      unf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (ret_bad)            unf_q <= 1'b1;
      if (call_go && rs_full) ovf_q <= 1'b1;
    end
  end

  assign pc           = pc_q;
  assign rs_underflow = unf_q;
  assign rs_overflow  = ovf_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
  import bseq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [15:0] op_target,
  input logic [7:0]  tos,
  input logic [7:0]  nos,
  input logic        carry,
  input logic [15:0] pc,
  input logic        pop_req,
  input logic [1:0]  pop_cnt,
  input logic        taken,
  input logic        rs_underflow,
  input logic        rs_overflow
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(pc)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!pop_req && !taken)); // R2
  AST_JMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_JMP) |=> pc == $past(op_target)); // R4
  AST_ZERO_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_JZ || op_code == OP_JNZ)) |-> (pop_req && pop_cnt == 2'd1)); // R5
  AST_CARRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_JC || op_code == OP_JNC)) |-> !pop_req); // R6
  AST_CARRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_JC) |-> (taken == carry)); // R6
  AST_EQ_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_JEQ || op_code == OP_JNE)) |-> (pop_req && pop_cnt == 2'd1)); // R7
  AST_EQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_JEQ) |-> (taken == (tos == nos))); // R7
  AST_CALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CALL) |=> pc == $past(op_target)); // R8
  AST_NO_UNDERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rs_underflow |=> rs_underflow); // R10
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rs_overflow |=> rs_overflow); // R11
endmodule

bind branch_seq bseq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .op_target    (op_target),
  .tos          (tos),
  .nos          (nos),
  .carry        (carry),
  .pc           (pc),
  .pop_req      (pop_req),
  .pop_cnt      (pop_cnt),
  .taken        (taken),
  .rs_underflow (rs_underflow),
  .rs_overflow  (rs_overflow)
);

// File: tb/test_branch_seq.sv
module test_branch_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] op_target = '0;
  logic [1:0]  op_len = 2'd1;
  logic [7:0]  tos = '0, nos = '0;
  logic        carry = 1'b0;
  logic [15:0] pc;
  logic        pop_req, taken, rs_underflow, rs_overflow;
  logic [1:0]  pop_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_pc;
  logic        m_unf, m_ovf;
  logic [15:0] m_rs[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_seq i_branch_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_target(op_target), .op_len(op_len), .tos(tos), .nos(nos), .carry(carry),
    .pc(pc), .pop_req(pop_req), .pop_cnt(pop_cnt), .taken(taken),
    .rs_underflow(rs_underflow), .rs_overflow(rs_overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; op_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = 16'h0000; m_unf = 1'b0; m_ovf = 1'b0; m_rs.delete();
    #1;
    chk("R1 pc", {16'h0, pc}, 32'h0);
    chk("R1 underflow", {31'h0, rs_underflow}, 32'h0);
    chk("R1 overflow", {31'h0, rs_overflow}, 32'h0);
  endtask

  // one cycle: drive, predict, compare outputs, then compare state
  task automatic step(input logic v, input logic [3:0] c, input logic [15:0] tgt,
                      input logic [1:0] len, input logic [7:0] t, input logic [7:0] n,
                      input logic cy, input string req);
    logic e_take, e_pop;
    logic [15:0] e_next;
    @(negedge clk);
    op_valid = v; op_code = c; op_target = tgt; op_len = len;
    tos = t; nos = n; carry = cy;
    e_take = 1'b0; e_pop = 1'b0;
    e_next = m_pc + 16'(len);
    if (v) begin
      case (c)
        4'd1: e_take = 1'b1;
        4'd2: begin e_pop = 1'b1; e_take = (t == 8'd0); end
        4'd3: begin e_pop = 1'b1; e_take = (t != 8'd0); end
        4'd4: e_take = cy;
        4'd5: e_take = !cy;
        4'd6: begin e_pop = 1'b1; e_take = (t == n); end
        4'd7: begin e_pop = 1'b1; e_take = (t != n); end
        4'd8: begin
          e_take = 1'b1;
          if (m_rs.size() == DEPTH) m_ovf = 1'b1;
          else m_rs.push_back(m_pc + 16'd3);
        end
        4'd9: begin
          if (m_rs.size() == 0) m_unf = 1'b1;
          else begin e_take = 1'b1; e_next = m_rs.pop_back(); end
        end
        default: ;
      endcase
      if (e_take && c != 4'd9) e_next = tgt;
    end else begin
      e_next = m_pc;
    end
    #1;
    chk({req, " taken"}, {31'h0, taken}, {31'h0, e_take});
    chk({req, " pop_req"}, {31'h0, pop_req}, {31'h0, e_pop});
    chk({req, " pop_cnt"}, {30'h0, pop_cnt}, {30'h0, (e_pop ? 2'd1 : 2'd0)});
    m_pc = e_next;
    @(posedge clk);
    #1;
    chk({req, " pc"}, {16'h0, pc}, {16'h0, m_pc});
    chk({req, " underflow"}, {31'h0, rs_underflow}, {31'h0, m_unf});
    chk({req, " overflow"}, {31'h0, rs_overflow}, {31'h0, m_ovf});
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: return right after reset finds an empty store (R10)
    step(1, 4'd9, 16'h0, 2'd1, 8'h0, 8'h0, 0, "R1 R10 empty return");
    do_reset();
    // R2 idle
    step(0, 4'd1, 16'h1234, 2'd3, 8'h0, 8'h0, 0, "R2 idle");
    step(0, 4'd2, 16'h1234, 2'd1, 8'h0, 8'h0, 0, "R2 idle");
    // R3 sequential advance
    step(1, 4'd0, 16'h5555, 2'd1, 8'h0, 8'h0, 0, "R3 len1");
    step(1, 4'd12, 16'h5555, 2'd3, 8'h0, 8'h0, 0, "R3 len3");
    // R4 jump, then R3 wrap
    step(1, 4'd1, 16'hFFFE, 2'd3, 8'h0, 8'h0, 0, "R4 jump");
    step(1, 4'd0, 16'h0000, 2'd3, 8'h0, 8'h0, 0, "R3 wrap");
    // R5
    step(1, 4'd2, 16'h0100, 2'd3, 8'h00, 8'h7, 0, "R5 jz taken");
    step(1, 4'd2, 16'h0200, 2'd3, 8'h05, 8'h7, 0, "R5 jz not");
    step(1, 4'd3, 16'h0300, 2'd3, 8'h05, 8'h7, 0, "R5 jnz taken");
    step(1, 4'd3, 16'h0400, 2'd3, 8'h00, 8'h7, 0, "R5 jnz not");
    // R6
    step(1, 4'd4, 16'h0500, 2'd3, 8'h00, 8'h0, 1, "R6 jc taken");
    step(1, 4'd4, 16'h0600, 2'd3, 8'h00, 8'h0, 0, "R6 jc not");
    step(1, 4'd5, 16'h0700, 2'd3, 8'h00, 8'h0, 0, "R6 jnc taken");
    step(1, 4'd5, 16'h0800, 2'd3, 8'h00, 8'h0, 1, "R6 jnc not");
    // R7
    step(1, 4'd6, 16'h0900, 2'd3, 8'h24, 8'h24, 0, "R7 jeq taken");
    step(1, 4'd6, 16'h0A00, 2'd3, 8'h24, 8'h25, 0, "R7 jeq not");
    step(1, 4'd7, 16'h0B00, 2'd3, 8'h24, 8'h25, 0, "R7 jne taken");
    step(1, 4'd7, 16'h0C00, 2'd3, 8'h24, 8'h24, 0, "R7 jne not");
    // R8 R9 nesting
    step(1, 4'd8, 16'h2000, 2'd3, 8'h0, 8'h0, 0, "R8 call1");
    step(1, 4'd8, 16'h3000, 2'd3, 8'h0, 8'h0, 0, "R8 call2");
    step(1, 4'd0, 16'h0, 2'd1, 8'h0, 8'h0, 0, "R3 body");
    step(1, 4'd9, 16'h0, 2'd1, 8'h0, 8'h0, 0, "R9 ret2");
    step(1, 4'd9, 16'h0, 2'd1, 8'h0, 8'h0, 0, "R9 ret1");
    // R11 fill and overflow, then R9 unwind and R10
    for (int i = 0; i < DEPTH; i++)
      step(1, 4'd8, 16'(16'h4000 + i * 16), 2'd3, 8'h0, 8'h0, 0, "R8 fill");
    step(1, 4'd8, 16'hEEEE, 2'd3, 8'h0, 8'h0, 0, "R11 overflow call");
    for (int i = 0; i < DEPTH; i++)
      step(1, 4'd9, 16'h0, 2'd1, 8'h0, 8'h0, 0, "R9 R11 unwind");
    step(1, 4'd9, 16'h0, 2'd3, 8'h0, 8'h0, 0, "R10 underflow");
    step(1, 4'd0, 16'h0, 2'd1, 8'h0, 8'h0, 0, "R10 sticky");
    // mixed random traffic
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [7:0] rt;
      rt = 8'($urandom_range(0, 3));
      step(1'($urandom_range(0, 5) != 0), 4'($urandom_range(0, 15)), 16'($urandom),
           ($urandom_range(0, 1) != 0) ? 2'd3 : 2'd1, rt, 8'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), "R3 R5 R6 R7 R8 R9 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule